// File: doc/BRIEF.md
# Byte-Serial Cipher Key Register with Choice-1 Wiring

This block collects a 64-bit block-cipher key that arrives one byte at a time on a valid/ready stream. It keeps 56 of the 64 bits and sorts them into two 28-bit halves, C and D, following the standard Permuted Choice 1 order. It does no bit shuffling in logic. Each half is built from three 8-bit shift chains and one 4-bit chain, and every chain has parallel outputs. Each port bit drives the head of one chain. The 4-bit chain of C empties into the 4-bit chain of D, so the two tails form a single 8-stage chain while the key loads. The eighth bit of every byte is its odd-parity bit. That bit is checked and then thrown away.

Once eight bytes have been accepted, the block raises `key_ready`. From then on each half works as a closed 28-position ring. On a rotate command both rings move together by one or two places: left for encryption, right for decryption. The two 28-bit outputs feed the next selection stage directly.

The stream has two rules on back-pressure. A byte moves only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops once the eighth byte has been taken, and it stays low until `load_start` opens a new key. While it is low the sender must hold its byte.

Top module: `key_reg_pc1`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `c_key` and `d_key` are zero, `key_ready` is 0, `parity_err` is 0 and `in_ready` is 1.
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 while fewer than eight bytes have been taken and 0 once eight have been taken. A byte offered while `in_ready` is 0 changes nothing.
- R3: C bit k appears on `c_key[28-k]`, and D bit k appears on `d_key[28-k]`. In `in_byte`, bit 7 is port bit 1 and bit 0 is port bit 8. Port bit 1 enters C bit 1, port bit 2 enters C bit 9 and port bit 3 enters C bit 17. On each taken byte, every bit of an 8-bit chain moves one position higher. After eight bytes, C bit 1 holds key bit 57 and C bit 8 holds key bit 1. Key bit 1 is the MSB of the first byte.
- R4: Port bit 7 enters D bit 1, port bit 6 enters D bit 9 and port bit 5 enters D bit 17. These D chains shift the same way as the C chains.
- R5: Port bit 4 enters C bit 25, and C bit 28 feeds D bit 25, so together they form one 8-stage chain. After eight bytes, C bits 25 to 28 hold key bits 60, 52, 44 and 36, and D bits 25 to 28 hold key bits 28, 20, 12 and 4.
- R6: Port bit 8 (`in_byte[0]`) is never stored. Changing it in any byte leaves `c_key` and `d_key` unchanged.
- R7: `key_ready` rises on the edge that takes the eighth byte.
- R8: With `key_ready` at 1, `rot_en` at 1 and `rot_dir` at 0, both halves rotate toward bit 1 (bit 1 wraps to bit 28) in one cycle. They move by 2 places if `rot_two` is 1 and by 1 place if it is 0. Each half rotates only within itself.
- R9: With `rot_dir` at 1 the rotation goes the other way: bit 28 wraps to bit 1. The amount is again 1 or 2 places.
- R10: While `key_ready` is 0, `rot_en` has no effect on `c_key` or `d_key`.
- R11: `parity_err` rises after any taken byte that has an even number of ones and stays high until `load_start`. The load still finishes normally after such a byte.
- R12: `load_start` clears C, D, the byte count and `parity_err` on the next edge. It takes priority over a byte and over a rotation offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Begins a new key: clears the halves, the count and the flag |
| in_valid | input | 1 | Key byte on `in_byte` is valid |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Key byte; bit 7 is port bit 1, bit 0 is the parity bit |
| rot_en | input | 1 | Rotate command |
| rot_dir | input | 1 | 0 rotates left (encrypt), 1 rotates right (decrypt) |
| rot_two | input | 1 | 1 rotates by two places, 0 by one |
| c_key | output | 28 | C half; C bit k on index 28-k |
| d_key | output | 28 | D half; D bit k on index 28-k |
| key_ready | output | 1 | Eight bytes have been taken |
| parity_err | output | 1 | A taken byte failed odd parity |

## Verification
A chain wired to the wrong port bit, or shifting the wrong way, shows up in `c_key` or `d_key` on the edge after the affected byte is taken. After the full eight-byte load it is a mismatch against the choice-1 order. A broken tail bridge shows only in D bits 25 to 28, and only once the first tail bit has passed through the four C stages. So the tail needs a check after a complete load rather than after each byte. An off-by-one in the byte count moves the `key_ready` edge and the fall of `in_ready` by one cycle. A rotation fault shows on the cycle after the command, as a half that is not an exact circular shift of its previous value.

// File: rtl/key_reg_pc1_pkg.sv
package key_reg_pc1_pkg;
  parameter int BYTE_W  = 8;
  parameter int SEG_W   = 8;
  parameter int NSEG    = 3;
  parameter int TAIL_W  = 4;
  localparam int HALF_W = NSEG * SEG_W + TAIL_W;
  localparam int NBYTES = SEG_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  // one-place circular move; right=1 moves bit k to k+1 (toward index 0)
  function automatic logic [HALF_W-1:0] ring_step(input logic [HALF_W-1:0] v,
                                                  input logic right);
    return right ? {v[0], v[HALF_W-1:1]} : {v[HALF_W-2:0], v[HALF_W-1]};
  endfunction
endpackage

// File: rtl/kr_half.sv
module kr_half
  import key_reg_pc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [NSEG-1:0]   seg_in,
  input  logic              tail_in,
  input  logic              rot_go,
  input  logic              rot_right,
  input  logic              rot_two,
  output logic [HALF_W-1:0] q,
  output logic              tail_out
);
  logic [HALF_W-1:0] q_r, shifted, once, twice;

  // each 8-bit chain: head at the low bit number, shifting toward higher numbers
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int HI = HALF_W - 1 - s * SEG_W;
    assign shifted[HI]                 = seg_in[s];
    assign shifted[HI-1 -: SEG_W-1]    = q_r[HI -: SEG_W-1];
  end

  assign shifted[TAIL_W-1]   = tail_in;
  assign shifted[TAIL_W-2:0] = q_r[TAIL_W-1:1];

  always_comb begin
    once  = ring_step(q_r, rot_right);
    twice = ring_step(once, rot_right);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        q_r <= '0;
    else if (clr)      q_r <= '0;
    else if (shift_en) q_r <= shifted;
    else if (rot_go)   q_r <= rot_two ? twice : once;
  end

  assign q        = q_r;
  assign tail_out = q_r[0];
endmodule

// File: rtl/kr_ctrl.sv
module kr_ctrl
  import key_reg_pc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              rot_en,
  output logic              in_ready,
  output logic              take,
  output logic              clr,
  output logic              rot_go,
  output logic              key_ready,
  output logic              parity_err
);
  logic [CNT_W-1:0] cnt;
  logic             err_r;

  assign key_ready  = (cnt == CNT_W'(NBYTES));
  assign in_ready   = !key_ready;
  assign clr        = load_start;
  assign take       = in_valid && in_ready && !load_start;
  assign rot_go     = rot_en && key_ready && !load_start;
  assign parity_err = err_r;

  always_ff @(posedge clk) begin
    if (!rst_n || load_start) begin
      cnt   <= '0;
      err_r <= 1'b0;
    end else if (take) begin
      cnt   <= cnt + 1'b1;
      err_r <= err_r | ~(^in_byte);
    end
  end
endmodule

// File: rtl/key_reg_pc1.sv
module key_reg_pc1
  import key_reg_pc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              rot_en,
  input  logic              rot_dir,
  input  logic              rot_two,
  output logic [27:0]       c_key,
  output logic [27:0]       d_key,
  output logic              key_ready,
  output logic              parity_err
);
  logic take, clr, rot_go, c_tail, d_tail;
  logic [NSEG-1:0] c_seg, d_seg;

  kr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .in_valid(in_valid),
    .in_byte(in_byte), .rot_en(rot_en), .in_ready(in_ready), .take(take),
    .clr(clr), .rot_go(rot_go), .key_ready(key_ready), .parity_err(parity_err)
  );

  // port bit p is in_byte[8-p]; C chains take port bits 1..3, D chains 7..5
  for (genvar s = 0; s < NSEG; s++) begin : g_map
    assign c_seg[s] = in_byte[BYTE_W-1-s];
    assign d_seg[s] = in_byte[1+s];
  end

  kr_half u_c (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(take), .seg_in(c_seg),
    .tail_in(in_byte[BYTE_W-4]), .rot_go(rot_go), .rot_right(rot_dir),
    .rot_two(rot_two), .q(c_key), .tail_out(c_tail)
  );

  kr_half u_d (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(take), .seg_in(d_seg),
    .tail_in(c_tail), .rot_go(rot_go), .rot_right(rot_dir),
    .rot_two(rot_two), .q(d_key), .tail_out(d_tail)
  );
endmodule

// File: rtl/key_reg_pc1_chk.sv
module key_reg_pc1_chk
  import key_reg_pc1_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        load_start,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_byte,
  input logic        rot_en,
  input logic        rot_dir,
  input logic        rot_two,
  input logic [27:0] c_key,
  input logic [27:0] d_key,
  input logic        key_ready,
  input logic        parity_err
);
  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |-> !in_ready);

  p_hold_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && !rot_en && !load_start) |=> ($stable(c_key) && $stable(d_key)));

  p_ready_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_ready) |-> $past(in_valid && in_ready));

  p_rotl1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && rot_en && !rot_dir && !rot_two && !load_start) |=>
      c_key == {$past(c_key[HALF_W-2:0]), $past(c_key[HALF_W-1])});

  p_rotr1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && rot_en && rot_dir && !rot_two && !load_start) |=>
      d_key == {$past(d_key[0]), $past(d_key[HALF_W-1:1])});

  p_no_early_rot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_ready && !(in_valid && in_ready) && !load_start) |=>
      ($stable(c_key) && $stable(d_key)));

  p_parity_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(^in_byte) && !load_start) |=> parity_err);

  p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> (!key_ready && !parity_err && c_key == '0 && d_key == '0));
endmodule

bind key_reg_pc1 key_reg_pc1_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_start(load_start), .in_valid(in_valid),
  .in_ready(in_ready), .in_byte(in_byte), .rot_en(rot_en), .rot_dir(rot_dir),
  .rot_two(rot_two), .c_key(c_key), .d_key(d_key), .key_ready(key_ready),
  .parity_err(parity_err)
);

// File: tb/sim_key_reg_pc1.sv
module sim_key_reg_pc1;
  logic clk = 1'b0, rst_n = 1'b0, load_start = 1'b0, in_valid = 1'b0;
  logic rot_en = 1'b0, rot_dir = 1'b0, rot_two = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, key_ready, parity_err;
  logic [27:0] c_key, d_key;
  int total = 0, bad = 0;
  logic [27:0] ec, ed, sc, sd;

  always #2.5 clk = ~clk;

  key_reg_pc1 u0 (.*);

  // {expected parity flag, key}
  localparam logic [64:0] VECS [5] = '{
    {1'b0, 64'h133457799BBCDFF1},
    {1'b0, 64'h0123456789ABCDEF},
    {1'b0, 64'h0E329232EA6D0D73},
    {1'b1, 64'hFFFFFFFFFFFFFFFF},
    {1'b1, 64'h8000000000000001}
  };

  function automatic logic kbit(input logic [63:0] k, input int n);
    return k[64-n];
  endfunction

  function automatic logic [27:0] exp_c(input logic [63:0] k);
    logic [27:0] r;
    for (int b = 1; b <= 28; b++) begin
      int n;
      if (b <= 24) n = 57 - 8 * ((b - 1) % 8) + (b - 1) / 8;
      else         n = 60 - 8 * (b - 25);
      r[28-b] = kbit(k, n);
    end
    return r;
  endfunction

  function automatic logic [27:0] exp_d(input logic [63:0] k);
    logic [27:0] r;
    for (int b = 1; b <= 28; b++) begin
      int n;
      if (b <= 24) n = 63 - 8 * ((b - 1) % 8) - (b - 1) / 8;
      else         n = 28 - 8 * (b - 25);
      r[28-b] = kbit(k, n);
    end
    return r;
  endfunction

  function automatic logic [27:0] turn(input logic [27:0] v, input logic right, input int amt);
    logic [27:0] r = v;
    for (int i = 0; i < amt; i++) r = right ? {r[0], r[27:1]} : {r[26:0], r[27]};
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic load_key(input logic [63:0] k, input logic flip);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = k[63-8*i -: 8] ^ {7'd0, flip};
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic start_key();
    @(negedge clk); load_start = 1'b1;
    @(negedge clk); load_start = 1'b0;
  endtask

  task automatic rotate(input logic right, input logic two);
    @(negedge clk); rot_en = 1'b1; rot_dir = right; rot_two = two;
    @(negedge clk); rot_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 c", 64'(c_key), 0);
    check("R1 d", 64'(d_key), 0);
    check("R1 ready", {key_ready, in_ready, parity_err}, 64'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {key_ready, in_ready, parity_err}, 64'b010);

    // table walk: R3 R4 R5 R7 R11 R2
    for (int v = 0; v < 5; v++) begin
      start_key();
      load_key(VECS[v][63:0], 1'b0);
      check("R3 R5 c half", 64'(c_key), 64'(exp_c(VECS[v][63:0])));
      check("R4 R5 d half", 64'(d_key), 64'(exp_d(VECS[v][63:0])));
      check("R7 key_ready", 64'(key_ready), 1);
      check("R2 in_ready low when full", 64'(in_ready), 0);
      check("R11 parity flag", 64'(parity_err), 64'(VECS[v][64]));
    end

    // R6: flipped parity bits give the same halves
    start_key();
    load_key(VECS[0][63:0], 1'b1);
    check("R6 c ignores parity bit", 64'(c_key), 64'(exp_c(VECS[0][63:0])));
    check("R6 d ignores parity bit", 64'(d_key), 64'(exp_d(VECS[0][63:0])));
    check("R11 load completes with error", {key_ready, parity_err}, 64'b11);

    // R2: byte offered while full changes nothing
    ec = c_key; ed = d_key;
    @(negedge clk); in_valid = 1'b1; in_byte = 8'h5A;
    @(negedge clk); in_valid = 1'b0;
    check("R2 back-pressure c", 64'(c_key), 64'(ec));
    check("R2 back-pressure d", 64'(d_key), 64'(ed));

    // R8 / R9 rotations
    start_key();
    load_key(VECS[1][63:0], 1'b0);
    ec = exp_c(VECS[1][63:0]); ed = exp_d(VECS[1][63:0]);
    rotate(1'b0, 1'b0); ec = turn(ec, 0, 1); ed = turn(ed, 0, 1);
    check("R8 left 1 c", 64'(c_key), 64'(ec));
    check("R8 left 1 d", 64'(d_key), 64'(ed));
    rotate(1'b0, 1'b1); ec = turn(ec, 0, 2); ed = turn(ed, 0, 2);
    check("R8 left 2 c", 64'(c_key), 64'(ec));
    check("R8 left 2 d", 64'(d_key), 64'(ed));
    rotate(1'b1, 1'b0); ec = turn(ec, 1, 1); ed = turn(ed, 1, 1);
    check("R9 right 1 c", 64'(c_key), 64'(ec));
    check("R9 right 1 d", 64'(d_key), 64'(ed));
    rotate(1'b1, 1'b1); ec = turn(ec, 1, 2); ed = turn(ed, 1, 2);
    check("R9 right 2 c", 64'(c_key), 64'(ec));
    check("R9 right 2 d", 64'(d_key), 64'(ed));
    check("R9 back to loaded c", 64'(c_key), 64'(exp_c(VECS[1][63:0])));

    // R10: rotation before key_ready ignored
    start_key();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = VECS[2][63-8*i -: 8];
    end
    @(negedge clk); in_valid = 1'b0;
    sc = c_key; sd = d_key;
    rotate(1'b0, 1'b1);
    check("R10 c unchanged", 64'(c_key), 64'(sc));
    check("R10 d unchanged", 64'(d_key), 64'(sd));
    check("R2 R10 ready states", {key_ready, in_ready}, 64'b01);

    // R12: load_start mid-load clears flag and halves
    @(negedge clk); in_valid = 1'b1; in_byte = 8'h00;
    @(negedge clk); in_valid = 1'b0;
    check("R11 even byte flags", 64'(parity_err), 1);
    start_key();
    check("R12 cleared", {key_ready, in_ready, parity_err}, 64'b010);
    check("R12 c cleared", 64'(c_key), 0);

    // R12: priority over rotation in the same cycle
    load_key(VECS[0][63:0], 1'b0);
    @(negedge clk); load_start = 1'b1; rot_en = 1'b1;
    @(negedge clk); load_start = 1'b0; rot_en = 1'b0;
    check("R12 priority c", 64'(c_key), 0);
    check("R12 priority ready", 64'(key_ready), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule